// File: doc/BRIEF.md
# Byte-Mapped Edge-Latching Interrupt Aggregator

The aggregator gathers 24 interrupt request lines into three groups of eight. Each group has a status byte and a mask byte, reached through a small byte-wide register port. Most request lines are edge-captured: a rising edge on an enabled line sets a sticky pending bit. That bit stays set until the host reads the status byte of its group, and the read clears it with no separate acknowledge.

One request line, chosen by a parameter, is level-sensitive. Its status bit shows the live input level and never latches. The block drives one combined interrupt line that is high whenever any status bit is set with its mask bit enabled. The host detects a new request on the rising edge of that line. It then reads the three status bytes and services the bits that are both set and enabled.

Requests are captured only while enabled. An edge that rises while its mask bit is 0 is dropped and does not come back when the line is enabled later.

Top module: `irq_byte_agg`

## Requirements
- R1: After reset all three mask bytes read 0x00, every edge-captured status bit is 0 and `irq_o` is 0 unless the level-sensitive line is both high and enabled.
- R2: Mask byte g (g = 0, 1, 2) sits at address 4+g. It is written with `wdata_i` when `wr_en_i` is high, and it reads back the value written. A mask bit of 1 enables its source.
- R3: A 0-to-1 change on an edge-sensitive source is judged against the input value of the previous clock. When the source's mask bit is 1, that change sets a pending bit, which stays set through any later input change until its status byte is read.
- R4: A rising edge while the mask bit is 0 sets nothing. Enabling the source afterwards, even while the input is still high, does not make it pending.
- R5: Status byte g sits at address g. A read (`rd_en_i` high) returns the current status in the same cycle and clears the edge-captured bits of that byte only, from the next cycle on.
- R6: An edge that is captured in the same cycle as the clearing read of its byte stays pending after the read.
- R7: The level-sensitive source (index `LEVEL_SRC`, default 0) has a status bit equal to its current input. The bit ignores the mask for display and is not cleared by a read.
- R8: `irq_o` is the OR of all status bits ANDed with their mask bits, and it follows them in the same cycle.
- R9: Writes to status addresses 0 to 2 change nothing. Addresses 3 and 7 read 0x00.
- R10: Source n appears in byte n/8 at bit n%8, in both the status and the mask bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | 24 | Interrupt request lines |
| addr_i | input | 3 | Register address |
| rd_en_i | input | 1 | Read strobe; clears the status byte that is read |
| wr_en_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, combinational from `addr_i` |
| irq_o | output | 1 | Combined interrupt request |

## Verification
Two actions can land in the same cycle: a status read that clears a byte, and a new edge captured into that same byte. The bench forces this on purpose. It raises a source in the very cycle its status byte is read, then reads the byte again to confirm the bit survived. The random phase produces further overlaps of edges, reads and mask writes, and checks each one against a reference model that applies the clear first and the capture after it.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int unsigned GRP_W_DEF  = 8;
  localparam int unsigned GRP_N_DEF  = 3;
  localparam int unsigned ADDR_W_DEF = 3;
endpackage

// File: rtl/irq_grp.sv
module irq_grp #(
  parameter int unsigned W         = 8,
  parameter bit          LEVEL_EN  = 1'b0,
  parameter int unsigned LEVEL_BIT = 0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] src_i,
  input  logic         mask_wr_i,
  input  logic [W-1:0] wdata_i,
  input  logic         clr_i,
  output logic [W-1:0] status_o,
  output logic [W-1:0] mask_o
);
  localparam logic [W-1:0] ONE_V  = {{(W-1){1'b0}}, 1'b1};
  localparam logic [W-1:0] LVL_M  = LEVEL_EN ? (ONE_V << LEVEL_BIT) : '0;
  localparam logic [W-1:0] EDGE_M = ~LVL_M;

  logic [W-1:0] prev_q, prev_d;
  logic [W-1:0] pend_q, pend_d;
  logic [W-1:0] mask_q, mask_d;
  logic [W-1:0] set_v;

  always_comb begin
    set_v  = src_i & ~prev_q & mask_q & EDGE_M;
    pend_d = ((clr_i ? '0 : pend_q) | set_v) & EDGE_M;
    mask_d = mask_wr_i ? wdata_i : mask_q;
    prev_d = src_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      pend_q <= '0;
      mask_q <= '0;
    end else begin
      prev_q <= prev_d;
      pend_q <= pend_d;
      if (mask_wr_i) mask_q <= mask_d;
    end
  end

  assign status_o = pend_q | (src_i & LVL_M);
  assign mask_o   = mask_q;

  // R4
  masked_edge_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend_q & ~$past(pend_q) & ~$past(mask_q)) == '0));

  // R3
  pend_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_i |=> ((pend_q & $past(pend_q)) == $past(pend_q)));

  // R5
  read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> ((pend_q & ~$past(src_i & ~prev_q)) == '0));

  // R2
  mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mask_wr_i |=> (mask_o == $past(wdata_i)));
endmodule

// File: rtl/irq_regif.sv
module irq_regif #(
  parameter int unsigned W      = 8,
  parameter int unsigned G      = 3,
  parameter int unsigned ADDR_W = 3
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rd_en_i,
  input  logic              wr_en_i,
  input  logic [G*W-1:0]    status_i,
  input  logic [G*W-1:0]    mask_i,
  output logic [G-1:0]      clr_o,
  output logic [G-1:0]      mask_wr_o,
  output logic [W-1:0]      rdata_o
);
  localparam int unsigned IDX_W = ADDR_W - 1;

  logic               is_mask;
  logic [IDX_W-1:0]   idx;

  assign is_mask = addr_i[ADDR_W-1];
  assign idx     = addr_i[IDX_W-1:0];

  always_comb begin
    rdata_o = '0;
    for (int g = 0; g < G; g++) begin
      clr_o[g]     = rd_en_i && !is_mask && (idx == IDX_W'(g));
      mask_wr_o[g] = wr_en_i &&  is_mask && (idx == IDX_W'(g));
      if (idx == IDX_W'(g))
        rdata_o = is_mask ? mask_i[g*W +: W] : status_i[g*W +: W];
    end
  end
endmodule

// File: rtl/irq_byte_agg.sv
module irq_byte_agg
  import irq_agg_pkg::*;
#(
  parameter int unsigned GRP_W     = GRP_W_DEF,
  parameter int unsigned GRP_N     = GRP_N_DEF,
  parameter int unsigned ADDR_W    = ADDR_W_DEF,
  parameter int unsigned LEVEL_SRC = 0
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [GRP_N*GRP_W-1:0] src_i,
  input  logic [ADDR_W-1:0]      addr_i,
  input  logic                   rd_en_i,
  input  logic                   wr_en_i,
  input  logic [GRP_W-1:0]       wdata_i,
  output logic [GRP_W-1:0]       rdata_o,
  output logic                   irq_o
);
  localparam int unsigned NSRC    = GRP_N * GRP_W;
  localparam int unsigned LVL_GRP = LEVEL_SRC / GRP_W;
  localparam int unsigned LVL_BIT = LEVEL_SRC % GRP_W;

  logic [NSRC-1:0]  status_all;
  logic [NSRC-1:0]  mask_all;
  logic [GRP_N-1:0] clr;
  logic [GRP_N-1:0] mask_wr;

  irq_regif #(.W(GRP_W), .G(GRP_N), .ADDR_W(ADDR_W)) u_regif (
    .addr_i    (addr_i),
    .rd_en_i   (rd_en_i),
    .wr_en_i   (wr_en_i),
    .status_i  (status_all),
    .mask_i    (mask_all),
    .clr_o     (clr),
    .mask_wr_o (mask_wr),
    .rdata_o   (rdata_o)
  );

  for (genvar g = 0; g < GRP_N; g++) begin : g_grp
    irq_grp #(
      .W         (GRP_W),
      .LEVEL_EN  (g == LVL_GRP),
      .LEVEL_BIT (LVL_BIT)
    ) u_grp (
      .clk       (clk),
      .rst_n     (rst_n),
      .src_i     (src_i[g*GRP_W +: GRP_W]),
      .mask_wr_i (mask_wr[g]),
      .wdata_i   (wdata_i),
      .clr_i     (clr[g]),
      .status_o  (status_all[g*GRP_W +: GRP_W]),
      .mask_o    (mask_all[g*GRP_W +: GRP_W])
    );
  end

  assign irq_o = |(status_all & mask_all);

  // R7
  level_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status_all[LEVEL_SRC] == src_i[LEVEL_SRC]);

  // R5
  one_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(clr));
endmodule

// File: tb/sim_irq_byte_agg.sv
module sim_irq_byte_agg;
  localparam int LVL = 0;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [23:0] src;
  logic [2:0]  addr;
  logic        rd, wr;
  logic [7:0]  wdata;
  logic [7:0]  rdata;
  logic        irq;

  int checks = 0;
  int errors = 0;

  logic [23:0] m_prev, m_pend, m_mask;

  irq_byte_agg u0 (
    .clk(clk), .rst_n(rst_n), .src_i(src), .addr_i(addr),
    .rd_en_i(rd), .wr_en_i(wr), .wdata_i(wdata),
    .rdata_o(rdata), .irq_o(irq)
  );

  always #2 clk = ~clk;

  function automatic logic [23:0] view();
    logic [23:0] v = m_pend;
    v[LVL] = src[LVL];
    return v;
  endfunction

  function automatic logic [7:0] exp_rd(input logic [2:0] a);
    logic [23:0] v = view();
    case (a)
      3'd0: return v[7:0];
      3'd1: return v[15:8];
      3'd2: return v[23:16];
      3'd4: return m_mask[7:0];
      3'd5: return m_mask[15:8];
      3'd6: return m_mask[23:16];
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input logic [23:0] s, input logic [2:0] a, input logic r,
                      input logic w, input logic [7:0] d, input string tag);
    logic [23:0] clr, set_v, ev;
    @(negedge clk);
    src = s; addr = a; rd = r; wr = w; wdata = d;
    #1;
    if (r) chk({tag, " rdata"}, rdata, exp_rd(a));
    chk({tag, " R8 irq"}, {7'd0, irq}, {7'd0, |(view() & m_mask)});
    @(posedge clk);
    ev = 24'hFFFFFF; ev[LVL] = 1'b0;
    clr = '0;
    if (r && a < 3'd3) clr[a*8 +: 8] = 8'hFF;
    set_v = s & ~m_prev & m_mask & ev;
    m_pend = ((m_pend & ~clr) | set_v) & ev;
    if (w && a[2] && a[1:0] != 2'd3) m_mask[a[1:0]*8 +: 8] = d;
    m_prev = s;
  endtask

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [23:0] s;
    process::self().srandom(32'd77);
    rst_n = 1'b0; src = '0; addr = '0; rd = 0; wr = 0; wdata = '0;
    m_prev = '0; m_pend = '0; m_mask = '0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 irq at reset", {7'd0, irq}, 8'h00);
    for (int a = 4; a < 7; a++) begin
      addr = 3'(a); #1;
      chk("R1 mask at reset", rdata, 8'h00);
    end
    @(negedge clk); rst_n = 1'b1;
    for (int a = 0; a < 3; a++) step('0, 3'(a), 1, 0, 0, "R1 status after reset");

    // R4: rise while masked, then enable while still high
    s = 24'h000200;
    step(s, 3'd1, 0, 0, 0, "R4 masked rise");
    step(s, 3'd5, 0, 1, 8'hFF, "R4 enable late");
    step(s, 3'd1, 1, 0, 0, "R4 not pending");
    chk("R4 explicit", exp_rd(3'd1), 8'h00);
    // R3 / R10: source 9 -> byte 1 bit 1
    step('0, 3'd1, 0, 0, 0, "R3 drop");
    step(s, 3'd5, 1, 0, 0, "R2 mask readback");
    step('0, 3'd1, 0, 0, 0, "R3 fall keeps bit");
    step('0, 3'd1, 1, 0, 0, "R10 bit 9 in byte 1");
    step('0, 3'd1, 1, 0, 0, "R5 cleared by read");
    // R6: edge on source 17 coincides with read of byte 2
    step('0, 3'd6, 0, 1, 8'hFF, "R2 enable byte 2");
    step(24'h020000, 3'd2, 1, 0, 0, "R6 edge during read");
    step(24'h020000, 3'd2, 1, 0, 0, "R6 survived");
    step(24'h020000, 3'd2, 1, 0, 0, "R5 cleared after");
    // R5: other bytes untouched by a read
    step(24'h000200, 3'd4, 0, 1, 8'hFF, "R2 enable byte 0");
    step(24'h000202, 3'd0, 1, 0, 0, "R5 read byte 0");
    step(24'h000202, 3'd1, 1, 0, 0, "R5 byte 1 kept");
    // R7: level source stays visible through reads
    step(24'h000001, 3'd0, 1, 0, 0, "R7 level high");
    step(24'h000001, 3'd0, 1, 0, 0, "R7 level after read");
    step(24'h000000, 3'd0, 1, 0, 0, "R7 level low");
    // R9: status writes ignored, unused addresses read 0
    step(24'h400000, 3'd2, 0, 0, 0, "R9 setup");
    step(24'h400000, 3'd2, 0, 1, 8'h00, "R9 write status");
    step(24'h400000, 3'd2, 1, 0, 0, "R9 status unchanged");
    step(24'h400000, 3'd3, 1, 1, 8'hFF, "R9 addr 3");
    step(24'h400000, 3'd7, 1, 1, 8'hFF, "R9 addr 7");
    step(24'h400000, 3'd4, 1, 0, 0, "R9 mask intact");

    s = '0;
    for (int i = 0; i < 4000; i++) begin
      logic [2:0] a = 3'($urandom_range(0, 7));
      s = s ^ (($urandom() & $urandom()) & 24'hFFFFFF);
      step(s, a, 1'($urandom_range(0, 1)), ($urandom_range(0, 7) == 0),
           8'($urandom()), "R8 random");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule